// File: doc/BRIEF.md
# Dual-Word-Line Memory with ROM Retrieval Sequencer

This block models a small memory whose rows each carry two word-line enables, together with a sequencer that recovers a fixed, wired-in constant from the same storage cells. Each bit is attached to one of the two word lines, and that attachment is the hidden constant. In normal operation both word lines move together, so the array is an ordinary single-port synchronous memory that answers reads and writes through the SRAM port.

A ROM request names one row. The sequencer first copies every row of that row's block into a save buffer. It then writes the target row in a way that turns the wiring into stored data, reads the result, and presents it on the ROM data output with a one-cycle valid pulse. Finally it writes the saved rows back. The busy flag covers the whole sequence, and SRAM requests are refused while it is high.

A parameter selects one of two exposure methods. The default uses two write steps. The alternative uses a single zero write followed by a read with a control line raised.

Top module: `rsram_top`

## Requirements
- R1: An SRAM request taken while `sram_ready` is high performs the write, or the read of `sram_addr`. A read returns its data on `sram_rdata` with `sram_rvalid` high exactly one cycle after acceptance.
- R2: `sram_ready` is low while `busy` is high, and also in an idle cycle where `rom_req` is high. A request offered while `sram_ready` is low is dropped and leaves the memory unchanged.
- R3: Row `r` holds the wired constant `ROM_SEED ^ (r * ROM_STEP)`, truncated to `DATA_W` bits; a bit value of 1 means attachment to the first word line. A ROM request for row `r` delivers this constant on `rom_data`.
- R4: `rom_valid` is high for exactly one cycle per retrieval, and `rom_data` changes only in a cycle where `rom_valid` is high.
- R5: `busy` rises the cycle after a ROM request is taken in idle.
- R6: After a retrieval, every row of every block holds the value it held before the request.
- R7: The SRAM port never returns wired constant data: a read returns the last value written, even when that value is the bitwise complement of the row's constant.
- R8: Every write issued outside a retrieval drives both word lines together, so all bits of the row take the written value.
- R9: With the default two-step method, `busy` stays high for exactly `2*ROWS_PER_BLK + 3` cycles. The single-step method takes one cycle fewer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sram_req | input | 1 | SRAM access request |
| sram_we | input | 1 | 1 = write, 0 = read |
| sram_addr | input | AW | Row address |
| sram_wdata | input | DATA_W | Write data |
| sram_ready | output | 1 | Request accepted this cycle when high |
| sram_rdata | output | DATA_W | Read data |
| sram_rvalid | output | 1 | Read data valid |
| rom_req | input | 1 | ROM retrieval request, taken in idle |
| rom_addr | input | AW | Row whose constant is retrieved |
| rom_valid | output | 1 | One-cycle pulse when rom_data is updated |
| rom_data | output | DATA_W | Retrieved constant, held between pulses |
| busy | output | 1 | Retrieval in progress |

## Verification
The assertions rely on `rom_req` being honoured only in idle. They also rely on the ROM constants being fixed by parameters, so the sequencer's write masks fully determine the row contents. The bench raises each ROM request for a single idle cycle and drives every input on the falling edge. It offers SRAM requests during retrieval only to observe the stall. It also offers one such request together with a ROM request, which exercises the idle-cycle priority.

// File: rtl/rsram_pkg.sv
package rsram_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SAVE,
        ST_ONES,
        ST_ZEROS,
        ST_READ,
        ST_RESTORE
    } seq_state_e;
endpackage

// File: rtl/rsram_cells.sv
module rsram_cells #(
    parameter int                DATA_W   = 8,
    parameter int                ROWS     = 16,
    parameter logic [DATA_W-1:0] ROM_SEED = 8'hA5,
    parameter int                ROM_STEP = 59,
    localparam int               AW       = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     wr_row,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wl1,
    input  logic              wl2,
    input  logic              re,
    input  logic [AW-1:0]     rd_row,
    input  logic              rcon,
    output logic [DATA_W-1:0] rdata
);
    logic [ROWS-1:0][DATA_W-1:0] conn;
    logic [ROWS-1:0][DATA_W-1:0] mem_d, mem_q;
    logic [DATA_W-1:0]           rdata_d, rdata_q;
    logic [DATA_W-1:0]           sel;

    for (genvar r = 0; r < ROWS; r++) begin : g_wiring
        assign conn[r] = ROM_SEED ^ DATA_W'(r * ROM_STEP);
    end

    always_comb begin
        mem_d   = mem_q;
        rdata_d = rdata_q;
        sel     = (conn[wr_row] & {DATA_W{wl1}}) | (~conn[wr_row] & {DATA_W{wl2}});
        if (we) begin
            mem_d[wr_row] = (mem_q[wr_row] & ~sel) | (wdata & sel);
        end
        if (re) begin
            rdata_d = mem_q[rd_row] | (conn[rd_row] & {DATA_W{rcon}});
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q   <= '0;
            rdata_q <= '0;
        end else begin
            mem_q   <= mem_d;
            rdata_q <= rdata_d;
        end
    end

    assign rdata = rdata_q;

    // R8: a write on both word lines stores every bit
    p_full_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        we && wl1 && wl2 |=> mem_q[$past(wr_row)] == $past(wdata));
endmodule

// File: rtl/rsram_seq.sv
module rsram_seq
    import rsram_pkg::*;
#(
    parameter int  DATA_W       = 8,
    parameter int  ROWS_PER_BLK = 4,
    parameter int  NUM_BLK      = 4,
    parameter bit  SINGLE_STEP  = 1'b0,
    localparam int ROWS         = ROWS_PER_BLK * NUM_BLK,
    localparam int AW           = $clog2(ROWS),
    localparam int RW           = $clog2(ROWS_PER_BLK)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sram_req,
    input  logic              sram_we,
    input  logic [AW-1:0]     sram_addr,
    input  logic [DATA_W-1:0] sram_wdata,
    output logic              sram_ready,
    output logic              sram_rvalid,
    input  logic              rom_req,
    input  logic [AW-1:0]     rom_addr,
    output logic              rom_valid,
    output logic [DATA_W-1:0] rom_data,
    output logic              busy,
    output logic              a_we,
    output logic [AW-1:0]     a_wr_row,
    output logic [DATA_W-1:0] a_wdata,
    output logic              a_wl1,
    output logic              a_wl2,
    output logic              a_re,
    output logic [AW-1:0]     a_rd_row,
    output logic              a_rcon,
    input  logic [DATA_W-1:0] a_rdata
);
    typedef struct packed {
        seq_state_e                          st;
        logic [RW-1:0]                       cnt;
        logic [AW-1:0]                       tgt;
        logic                                cap_v;
        logic [RW-1:0]                       cap_i;
        logic                                rom_cap;
        logic                                rvalid;
        logic                                rom_v;
        logic [DATA_W-1:0]                   rom_d;
        logic [ROWS_PER_BLK-1:0][DATA_W-1:0] save;
    } seq_regs_t;

    seq_regs_t     d, q;
    logic [AW-1:0] blk_row;
    logic          last_row;

    assign blk_row  = {q.tgt[AW-1:RW], q.cnt};
    assign last_row = (q.cnt == RW'(ROWS_PER_BLK - 1));

    always_comb begin
        d         = q;
        d.cap_v   = 1'b0;
        d.rom_cap = 1'b0;
        d.rvalid  = 1'b0;
        d.rom_v   = 1'b0;
        a_we      = 1'b0;
        a_wl1     = 1'b0;
        a_wl2     = 1'b0;
        a_wr_row  = q.tgt;
        a_wdata   = '0;
        a_re      = 1'b0;
        a_rd_row  = q.tgt;
        a_rcon    = 1'b0;
        sram_ready = (q.st == ST_IDLE) && !rom_req;

        if (q.cap_v) d.save[q.cap_i] = a_rdata;
        if (q.rom_cap) begin
            d.rom_d = a_rdata;
            d.rom_v = 1'b1;
        end

        case (q.st)
            ST_IDLE: begin
                if (rom_req) begin
                    d.st  = ST_SAVE;
                    d.tgt = rom_addr;
                    d.cnt = '0;
                end else if (sram_req) begin
                    if (sram_we) begin
                        a_we     = 1'b1;
                        a_wl1    = 1'b1;
                        a_wl2    = 1'b1;
                        a_wr_row = sram_addr;
                        a_wdata  = sram_wdata;
                    end else begin
                        a_re     = 1'b1;
                        a_rd_row = sram_addr;
                        d.rvalid = 1'b1;
                    end
                end
            end
            ST_SAVE: begin
                a_re     = 1'b1;
                a_rd_row = blk_row;
                d.cap_v  = 1'b1;
                d.cap_i  = q.cnt;
                d.cnt    = q.cnt + 1'b1;
                if (last_row) begin
                    d.cnt = '0;
                    d.st  = SINGLE_STEP ? ST_ZEROS : ST_ONES;
                end
            end
            ST_ONES: begin
                a_we    = 1'b1;
                a_wl1   = 1'b1;
                a_wl2   = 1'b1;
                a_wdata = '1;
                d.st    = ST_ZEROS;
            end
            ST_ZEROS: begin
                a_we    = 1'b1;
                a_wl1   = SINGLE_STEP;
                a_wl2   = 1'b1;
                a_wdata = '0;
                d.st    = ST_READ;
            end
            ST_READ: begin
                a_re      = 1'b1;
                a_rcon    = SINGLE_STEP;
                d.rom_cap = 1'b1;
                d.cnt     = '0;
                d.st      = ST_RESTORE;
            end
            ST_RESTORE: begin
                a_we     = 1'b1;
                a_wl1    = 1'b1;
                a_wl2    = 1'b1;
                a_wr_row = blk_row;
                a_wdata  = q.save[q.cnt];
                d.cnt    = q.cnt + 1'b1;
                if (last_row) begin
                    d.cnt = '0;
                    d.st  = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sram_rvalid = q.rvalid;
    assign rom_valid   = q.rom_v;
    assign rom_data    = q.rom_d;
    assign busy        = (q.st != ST_IDLE);

    p_read_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sram_req && sram_ready && !sram_we |=> sram_rvalid);
    p_stall_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sram_ready);
    p_rom_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rom_valid |=> !rom_valid);
    p_rom_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_valid |-> $stable(rom_data));
    p_busy_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rom_req && !busy |=> busy);
    p_paired_lines_r8: assert property (@(posedge clk) disable iff (!rst_n)
        a_we && !busy |-> a_wl1 == a_wl2);
endmodule

// File: rtl/rsram_top.sv
module rsram_top #(
    parameter int                DATA_W       = 8,
    parameter int                ROWS_PER_BLK = 4,
    parameter int                NUM_BLK      = 4,
    parameter bit                SINGLE_STEP  = 1'b0,
    parameter logic [DATA_W-1:0] ROM_SEED     = 8'hA5,
    parameter int                ROM_STEP     = 59,
    localparam int               ROWS         = ROWS_PER_BLK * NUM_BLK,
    localparam int               AW           = $clog2(ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sram_req,
    input  logic              sram_we,
    input  logic [AW-1:0]     sram_addr,
    input  logic [DATA_W-1:0] sram_wdata,
    output logic              sram_ready,
    output logic [DATA_W-1:0] sram_rdata,
    output logic              sram_rvalid,
    input  logic              rom_req,
    input  logic [AW-1:0]     rom_addr,
    output logic              rom_valid,
    output logic [DATA_W-1:0] rom_data,
    output logic              busy
);
    logic              a_we, a_wl1, a_wl2, a_re, a_rcon;
    logic [AW-1:0]     a_wr_row, a_rd_row;
    logic [DATA_W-1:0] a_wdata, a_rdata;

    rsram_seq #(
        .DATA_W(DATA_W), .ROWS_PER_BLK(ROWS_PER_BLK),
        .NUM_BLK(NUM_BLK), .SINGLE_STEP(SINGLE_STEP)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .sram_req(sram_req), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_ready(sram_ready), .sram_rvalid(sram_rvalid),
        .rom_req(rom_req), .rom_addr(rom_addr), .rom_valid(rom_valid),
        .rom_data(rom_data), .busy(busy),
        .a_we(a_we), .a_wr_row(a_wr_row), .a_wdata(a_wdata),
        .a_wl1(a_wl1), .a_wl2(a_wl2), .a_re(a_re), .a_rd_row(a_rd_row),
        .a_rcon(a_rcon), .a_rdata(a_rdata)
    );

    rsram_cells #(
        .DATA_W(DATA_W), .ROWS(ROWS), .ROM_SEED(ROM_SEED), .ROM_STEP(ROM_STEP)
    ) u_cells (
        .clk(clk), .rst_n(rst_n),
        .we(a_we), .wr_row(a_wr_row), .wdata(a_wdata),
        .wl1(a_wl1), .wl2(a_wl2), .re(a_re), .rd_row(a_rd_row),
        .rcon(a_rcon), .rdata(a_rdata)
    );

    assign sram_rdata = a_rdata;
endmodule

// File: tb/rsram_top_test.sv
`timescale 1ns/1ps
module rsram_top_test;
    localparam int RPB  = 4;
    localparam int ROWS = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sram_req = 1'b0, sram_we = 1'b0;
    logic [3:0] sram_addr = '0;
    logic [7:0] sram_wdata = '0;
    logic       sram_ready, sram_rvalid;
    logic [7:0] sram_rdata;
    logic       rom_req = 1'b0;
    logic [3:0] rom_addr = '0;
    logic       rom_valid, busy;
    logic [7:0] rom_data;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] shadow [ROWS];

    always #2 clk = ~clk;

    rsram_top uut (
        .clk(clk), .rst_n(rst_n),
        .sram_req(sram_req), .sram_we(sram_we), .sram_addr(sram_addr),
        .sram_wdata(sram_wdata), .sram_ready(sram_ready), .sram_rdata(sram_rdata),
        .sram_rvalid(sram_rvalid), .rom_req(rom_req), .rom_addr(rom_addr),
        .rom_valid(rom_valid), .rom_data(rom_data), .busy(busy)
    );

    function automatic logic [7:0] rom_of(int r);
        return 8'hA5 ^ 8'(r * 59);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(int row, logic [7:0] val);
        @(negedge clk);
        sram_req = 1'b1; sram_we = 1'b1; sram_addr = 4'(row); sram_wdata = val;
        @(negedge clk);
        sram_req = 1'b0; sram_we = 1'b0;
        shadow[row] = val;
    endtask

    task automatic rd_check(int row, string req);
        @(negedge clk);
        sram_req = 1'b1; sram_we = 1'b0; sram_addr = 4'(row);
        @(negedge clk);
        sram_req = 1'b0;
        chk({req, " rvalid"}, 32'(sram_rvalid), 32'd1);
        chk({req, " rdata"}, 32'(sram_rdata), 32'(shadow[row]));
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 100 && busy; g++) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R5 reset busy", 32'(busy), 32'd0);
        chk("R4 reset rom_valid", 32'(rom_valid), 32'd0);
        chk("R4 reset rom_data", 32'(rom_data), 32'd0);
        chk("R2 reset ready", 32'(sram_ready), 32'd1);
        chk("R1 reset rvalid", 32'(sram_rvalid), 32'd0);
    endtask

    task automatic t_sram();
        for (int r = 0; r < ROWS; r++) wr(r, ~rom_of(r));
        for (int r = 0; r < ROWS; r++) rd_check(r, "R7 complement readback");
        for (int r = 0; r < ROWS; r++) wr(r, 8'(r * 17 + 3));
        for (int r = 0; r < ROWS; r += 3) rd_check(r, "R1 R8 readback");
    endtask

    task automatic t_rom(int row);
        int cyc = 0;
        int vcnt = 0;
        logic [7:0] got = '0;
        @(negedge clk);
        rom_req = 1'b1; rom_addr = 4'(row);
        @(negedge clk);
        rom_req = 1'b0;
        chk("R5 busy after request", 32'(busy), 32'd1);
        for (int g = 0; g < 100 && busy; g++) begin
            cyc++;
            if (rom_valid) begin vcnt++; got = rom_data; end
            @(negedge clk);
        end
        if (rom_valid) begin vcnt++; got = rom_data; end
        chk("R9 busy length", 32'(cyc), 32'(2 * RPB + 3));
        chk("R4 single valid pulse", 32'(vcnt), 32'd1);
        chk("R3 rom word", 32'(got), 32'(rom_of(row)));
        repeat (3) @(negedge clk);
        chk("R4 rom_data held", 32'(rom_data), 32'(rom_of(row)));
        chk("R4 valid low after", 32'(rom_valid), 32'd0);
        for (int r = 0; r < ROWS; r++) rd_check(r, "R6 contents kept");
    endtask

    task automatic t_stall();
        @(negedge clk);
        rom_req = 1'b1; rom_addr = 4'd9;
        sram_req = 1'b1; sram_we = 1'b1; sram_addr = 4'd2; sram_wdata = 8'h3C;
        #0.5;
        chk("R2 ready low with rom_req", 32'(sram_ready), 32'd0);
        @(negedge clk);
        rom_req = 1'b0;
        sram_addr = 4'd1; sram_wdata = 8'hEE;
        for (int i = 0; i < 3; i++) begin
            #0.5;
            chk("R2 ready low while busy", 32'(sram_ready), 32'd0);
            @(negedge clk);
        end
        sram_req = 1'b0; sram_we = 1'b0;
        wait_idle();
        rd_check(1, "R2 stalled write dropped");
        rd_check(2, "R2 collided write dropped");
        chk("R3 rom word row 9", 32'(rom_data), 32'(rom_of(9)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sram();
        t_rom(5);
        t_rom(14);
        t_rom(0);
        t_stall();
        wr(7, 8'h00);
        wr(6, 8'hFF);
        t_rom(7);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule